// File: doc/BRIEF.md
# Priority-Arbitrated Shared Memory Port

This block puts three client ports in front of a single downstream memory server. Each client presents a request that holds an address and a write flag. When the flag is set, the request also carries a data word and is a write. When the flag is clear, the request is a read. A fixed-priority arbiter picks one eligible request each cycle and forwards it downstream in the same cycle.

Writes complete silently. A read returns exactly one data word, and that word is steered back to the client that asked for it. Each client has a one-entry response slot, so a client that is slow to collect its data never stalls the other clients.

The downstream server takes one request per handshake and answers reads in issue order. A small FIFO of port indices records which port each outstanding read belongs to. Every channel uses a valid/ready handshake.

Top module: `shared_mem_port`

## Requirements
- R1: While `rst` is high, `cl_req_ready`, `mem_req_valid` and `mem_rsp_ready` are all low. The cycle after a reset edge, every `cl_rsp_valid` bit is low.
- R2: An accepted write (`cl_req_wr`=1) appears downstream with the same address and data and with `mem_req_wr`=1. It never raises any `cl_rsp_valid` bit.
- R3: An accepted read (`cl_req_wr`=0) appears downstream with its address and `mem_req_wr`=0. Its response data is presented only on the issuing port's `cl_rsp_valid`/`cl_rsp_data`.
- R4: When several ports are eligible, the lowest-numbered one wins: port 0 before port 1, and port 1 before port 2. At most one `cl_req_ready` bit is high, and only on a port whose `cl_req_valid` is high.
- R5: While `mem_req_ready` is low, no `cl_req_ready` bit is raised.
- R6: A port whose earlier read is still outstanding or still uncollected has its reads held off (`cl_req_ready` low for that port). Writes from the same port are still accepted.
- R7: A response left uncollected on one port does not stop another port from issuing a read and receiving its data.
- R8: Responses that return in issue order are routed to their issuing ports even when several reads from different ports are in flight at once. The ports may collect them in any order.
- R9: A raised `cl_rsp_valid` bit stays high with unchanged `cl_rsp_data` until `cl_rsp_ready` for that port is high at a clock edge. After that edge it falls.
- R10: `mem_rsp_ready` is high only while at least one forwarded read has not yet been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cl_req_valid | input | NPORT | Request valid per client |
| cl_req_ready | output | NPORT | Request accepted per client |
| cl_req_wr | input | NPORT | 1 = write, 0 = read, per client |
| cl_req_addr | input | NPORT x AW | Request address per client |
| cl_req_wdata | input | NPORT x DW | Write data per client |
| cl_rsp_valid | output | NPORT | Read data waiting per client |
| cl_rsp_ready | input | NPORT | Client takes its read data |
| cl_rsp_data | output | NPORT x DW | Read data per client |
| mem_req_valid | output | 1 | Downstream request valid |
| mem_req_ready | input | 1 | Downstream accepts request |
| mem_req_wr | output | 1 | Downstream request is a write |
| mem_req_addr | output | AW | Downstream address |
| mem_req_wdata | output | DW | Downstream write data |
| mem_rsp_valid | input | 1 | Downstream read data valid |
| mem_rsp_ready | output | 1 | Block accepts downstream read data |
| mem_rsp_data | input | DW | Downstream read data |

## Verification
The bench raises all three ports in the same cycle and watches the grant move from port 0 to port 2. It then has the ports collect their responses in reverse order. A mis-ordered arbiter, or a tag FIFO that pops the wrong entry, would hand one port another port's data. A separate test parks a response on port 2 and then checks three things: port 2's read stays blocked, its write still passes, and port 0 can complete a full read. A design that coupled the slots, or blocked writes along with reads, would stall here. Other checks hold `mem_req_ready` low and confirm no grant is given, and confirm that writes leave every response channel idle.

// File: rtl/smp_pkg.sv
package smp_pkg;

    localparam int unsigned SMP_AW = 16;
    localparam int unsigned SMP_DW = 16;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } smp_op_e;

    typedef struct packed {
        smp_op_e             op;
        logic [SMP_AW-1:0]   addr;
        logic [SMP_DW-1:0]   wdata;
    } smp_req_t;

    function automatic smp_req_t smp_pack(input logic wr,
                                          input logic [SMP_AW-1:0] addr,
                                          input logic [SMP_DW-1:0] wdata);
        smp_req_t r;
        r.op    = wr ? OP_WRITE : OP_READ;
        r.addr  = addr;
        r.wdata = wdata;
        return r;
    endfunction

endpackage

// File: rtl/smp_arbiter.sv
module smp_arbiter #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // blocked[i] is set when any lower-numbered port requests
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign blocked[i+1] = blocked[i] | req[i];
        assign gnt[i]       = req[i] & ~blocked[i];
    end
endmodule

// File: rtl/smp_tag_fifo.sv
module smp_tag_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    input  logic          pop,
    output logic [TW-1:0] head_tag,
    output logic          empty,
    output logic          full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [TW-1:0] store [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;

    logic do_push, do_pop;
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign empty    = (count == '0);
    assign full     = (count == FULLC);
    assign head_tag = store[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                store[wptr] <= push_tag;
                wptr        <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (do_pop)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/smp_rsp_slot.sv
module smp_rsp_slot #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_sent,
    input  logic          fill,
    input  logic [DW-1:0] fill_data,
    input  logic          take,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    logic taken;
    assign taken = take && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (rd_sent)
                busy <= 1'b1;
            else if (taken)
                busy <= 1'b0;
            if (fill) begin
                rsp_valid <= 1'b1;
                rsp_data  <= fill_data;
            end else if (taken) begin
                rsp_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/shared_mem_port.sv
module shared_mem_port
    import smp_pkg::*;
#(
    parameter int unsigned NPORT     = 3,
    parameter int unsigned AW        = SMP_AW,
    parameter int unsigned DW        = SMP_DW,
    parameter int unsigned TAG_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPORT-1:0]          cl_req_valid,
    output logic [NPORT-1:0]          cl_req_ready,
    input  logic [NPORT-1:0]          cl_req_wr,
    input  logic [NPORT-1:0][AW-1:0]  cl_req_addr,
    input  logic [NPORT-1:0][DW-1:0]  cl_req_wdata,
    output logic [NPORT-1:0]          cl_rsp_valid,
    input  logic [NPORT-1:0]          cl_rsp_ready,
    output logic [NPORT-1:0][DW-1:0]  cl_rsp_data,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic                      mem_req_wr,
    output logic [AW-1:0]             mem_req_addr,
    output logic [DW-1:0]             mem_req_wdata,
    input  logic                      mem_rsp_valid,
    output logic                      mem_rsp_ready,
    input  logic [DW-1:0]             mem_rsp_data
);
    localparam int unsigned TW = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic [NPORT-1:0] busy, eligible, gnt, fill;
    logic             tag_full, tag_empty, fire, rd_fwd, rsp_take;
    logic [TW-1:0]    gnt_idx, head_idx;
    smp_req_t         sel;

    // A read needs an idle slot and room in the tag FIFO; writes only need a slot-free path
    always_comb begin
        for (int i = 0; i < NPORT; i++)
            eligible[i] = !rst && cl_req_valid[i] &&
                          (cl_req_wr[i] || (!busy[i] && !tag_full));
    end

    smp_arbiter #(.N(NPORT)) u_arb (
        .req (eligible),
        .gnt (gnt)
    );

    always_comb begin
        sel     = '0;
        gnt_idx = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (gnt[i]) begin
                sel     = smp_pack(cl_req_wr[i], SMP_AW'(cl_req_addr[i]),
                                   SMP_DW'(cl_req_wdata[i]));
                gnt_idx = TW'(i);
            end
        end
    end

    assign mem_req_valid = |gnt;
    assign mem_req_wr    = (sel.op == OP_WRITE);
    assign mem_req_addr  = AW'(sel.addr);
    assign mem_req_wdata = DW'(sel.wdata);
    assign fire          = mem_req_valid && mem_req_ready;
    assign cl_req_ready  = fire ? gnt : '0;
    assign rd_fwd        = fire && (sel.op == OP_READ);

    smp_tag_fifo #(.DEPTH(TAG_DEPTH), .TW(TW)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .push     (rd_fwd),
        .push_tag (gnt_idx),
        .pop      (rsp_take),
        .head_tag (head_idx),
        .empty    (tag_empty),
        .full     (tag_full)
    );

    assign mem_rsp_ready = !rst && !tag_empty && !cl_rsp_valid[head_idx];
    assign rsp_take      = mem_rsp_valid && mem_rsp_ready;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign fill[p] = rsp_take && (head_idx == TW'(p));

        smp_rsp_slot #(.DW(DW)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .rd_sent   (rd_fwd && gnt[p]),
            .fill      (fill[p]),
            .fill_data (mem_rsp_data),
            .take      (cl_rsp_ready[p]),
            .busy      (busy[p]),
            .rsp_valid (cl_rsp_valid[p]),
            .rsp_data  (cl_rsp_data[p])
        );
    end
endmodule

// File: rtl/smp_checker.sv
module smp_checker #(
    parameter int unsigned NPORT = 3,
    parameter int unsigned DW    = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NPORT-1:0]         cl_req_valid,
    input logic [NPORT-1:0]         cl_req_ready,
    input logic [NPORT-1:0]         cl_rsp_valid,
    input logic [NPORT-1:0]         cl_rsp_ready,
    input logic [NPORT-1:0][DW-1:0] cl_rsp_data,
    input logic                     mem_req_valid,
    input logic                     mem_req_ready,
    input logic                     mem_req_wr,
    input logic                     mem_rsp_valid,
    input logic                     mem_rsp_ready
);
    logic [7:0] outstanding;

    always_ff @(posedge clk) begin
        if (rst)
            outstanding <= '0;
        else
            outstanding <= outstanding
                         + 8'(mem_req_valid && mem_req_ready && !mem_req_wr)
                         - 8'(mem_rsp_valid && mem_rsp_ready);
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> (cl_req_ready == '0 && !mem_req_valid && !mem_rsp_ready));

    a_r1_slots_clear: assert property (@(posedge clk)
        rst |=> (cl_rsp_valid == '0));

    a_r4_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cl_req_ready) && ((cl_req_ready & ~cl_req_valid) == '0));

    a_r5_backpressure: assert property (@(posedge clk) disable iff (rst)
        !mem_req_ready |-> (cl_req_ready == '0));

    a_r10_rsp_needs_read: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_ready |-> (outstanding != 8'd0));

    for (genvar p = 0; p < NPORT; p++) begin : g_hold
        a_r9_rsp_hold: assert property (@(posedge clk) disable iff (rst)
            (cl_rsp_valid[p] && !cl_rsp_ready[p]) |=>
                (cl_rsp_valid[p] && $stable(cl_rsp_data[p])));

        a_r9_rsp_drop: assert property (@(posedge clk) disable iff (rst)
            (cl_rsp_valid[p] && cl_rsp_ready[p]) |=> !cl_rsp_valid[p]);
    end
endmodule

bind shared_mem_port smp_checker #(.NPORT(NPORT), .DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cl_req_valid  (cl_req_valid),
    .cl_req_ready  (cl_req_ready),
    .cl_rsp_valid  (cl_rsp_valid),
    .cl_rsp_ready  (cl_rsp_ready),
    .cl_rsp_data   (cl_rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_wr    (mem_req_wr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready)
);

// File: tb/sim_shared_mem_port.sv
`timescale 1ns/1ps
module sim_shared_mem_port;
    localparam int NP = 3;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NP-1:0]          cl_req_valid = '0, cl_req_wr = '0, cl_rsp_ready = '0;
    logic [NP-1:0][AW-1:0]  cl_req_addr  = '0;
    logic [NP-1:0][DW-1:0]  cl_req_wdata = '0;
    logic [NP-1:0]          cl_req_ready, cl_rsp_valid;
    logic [NP-1:0][DW-1:0]  cl_rsp_data;
    logic                   mem_req_valid, mem_req_wr, mem_rsp_ready;
    logic                   mem_req_ready = 1'b1;
    logic [AW-1:0]          mem_req_addr;
    logic [DW-1:0]          mem_req_wdata;
    logic                   mem_rsp_valid = 1'b0;
    logic [DW-1:0]          mem_rsp_data  = '0;

    shared_mem_port u0 (
        .clk(clk), .rst(rst),
        .cl_req_valid(cl_req_valid), .cl_req_ready(cl_req_ready),
        .cl_req_wr(cl_req_wr), .cl_req_addr(cl_req_addr), .cl_req_wdata(cl_req_wdata),
        .cl_rsp_valid(cl_rsp_valid), .cl_rsp_ready(cl_rsp_ready), .cl_rsp_data(cl_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_wr(mem_req_wr), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data)
    );

    // Behavioural memory: in-order read answers
    logic [DW-1:0] mem [16];
    logic [DW-1:0] rdq [$];
    logic          last_wr;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_wdata;
    int            reads_seen = 0;

    initial for (int i = 0; i < 16; i++) mem[i] = '0;

    always @(posedge clk) begin
        if (!rst && mem_rsp_valid && mem_rsp_ready) void'(rdq.pop_front());
        if (!rst && mem_req_valid && mem_req_ready) begin
            last_wr    = mem_req_wr;
            last_addr  = mem_req_addr;
            last_wdata = mem_req_wdata;
            if (mem_req_wr) mem[mem_req_addr[3:0]] = mem_req_wdata;
            else begin rdq.push_back(mem[mem_req_addr[3:0]]); reads_seen++; end
        end
    end

    always @(negedge clk) begin
        if (rdq.size() > 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rdq[0];
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic issue(input int p, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit ok;
        @(negedge clk);
        cl_req_valid[p] = 1'b1; cl_req_wr[p] = wr;
        cl_req_addr[p]  = a;    cl_req_wdata[p] = d;
        forever begin
            #9 ok = cl_req_ready[p];
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
        @(negedge clk);
        cl_req_valid[p] = 1'b0;
    endtask

    task automatic collect(input int p, input logic [DW-1:0] exp, input string req);
        int w = 0;
        while (!cl_rsp_valid[p] && w < 40) begin @(negedge clk); w++; end
        chk(req, cl_rsp_valid[p], 1'b1);
        chk(req, cl_rsp_data[p], exp);
        cl_rsp_ready[p] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cl_rsp_ready[p] = 1'b0;
        chk("R9", cl_rsp_valid[p], 1'b0);
    endtask

    typedef struct packed {
        logic [1:0]    port;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;   // write data, or expected read data
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{2'd0, 1'b1, 16'h0003, 16'h1111},
        '{2'd1, 1'b1, 16'h0005, 16'h2222},
        '{2'd2, 1'b1, 16'h0007, 16'h3333},
        '{2'd2, 1'b0, 16'h0003, 16'h1111},
        '{2'd0, 1'b0, 16'h0005, 16'h2222},
        '{2'd1, 1'b0, 16'h0007, 16'h3333},
        '{2'd1, 1'b1, 16'h0003, 16'h4444},
        '{2'd0, 1'b0, 16'h0003, 16'h4444}
    };

    initial begin
        // Reset behaviour
        repeat (3) @(negedge clk);
        cl_req_valid = '1;
        #9;
        chk("R1", cl_req_ready, '0);
        chk("R1", mem_req_valid, 1'b0);
        chk("R1", mem_rsp_ready, 1'b0);
        @(negedge clk);
        cl_req_valid = '0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", cl_rsp_valid, '0);
        chk("R10", mem_rsp_ready, 1'b0);

        // Vector table: one request at a time
        for (int k = 0; k <= 7; k++) begin
            issue(int'(VEC[k].port), VEC[k].wr, VEC[k].addr, VEC[k].data);
            if (VEC[k].wr) begin
                chk("R2", {last_wr, last_addr, last_wdata}, {1'b1, VEC[k].addr, VEC[k].data});
                repeat (3) @(negedge clk);
                chk("R2", cl_rsp_valid, '0);
            end else begin
                chk("R3", {last_wr, last_addr}, {1'b0, VEC[k].addr});
                while (cl_rsp_valid == '0) @(negedge clk);
                chk("R3", cl_rsp_valid, 3'b1 << VEC[k].port);
                collect(int'(VEC[k].port), VEC[k].data, "R3");
            end
        end
        chk("R10", mem_rsp_ready, 1'b0);

        // Back-pressure from downstream
        @(negedge clk);
        mem_req_ready = 1'b0;
        cl_req_valid[1] = 1'b1; cl_req_wr[1] = 1'b0; cl_req_addr[1] = 16'h0005;
        repeat (2) begin
            #9 chk("R5", cl_req_ready, '0);
            chk("R5", mem_req_valid, 1'b1);
            @(negedge clk);
        end
        cl_req_valid[1] = 1'b0;
        mem_req_ready = 1'b1;

        // Simultaneous reads on all ports: priority and routing
        @(negedge clk);
        cl_req_wr = '0;
        cl_req_addr[0] = 16'h0003; cl_req_addr[1] = 16'h0005; cl_req_addr[2] = 16'h0007;
        cl_req_valid = 3'b111;
        #9 chk("R4", cl_req_ready, 3'b001);
        @(negedge clk); cl_req_valid[0] = 1'b0;
        #9 chk("R4", cl_req_ready, 3'b010);
        @(negedge clk); cl_req_valid[1] = 1'b0;
        #9 chk("R4", cl_req_ready, 3'b100);
        @(negedge clk); cl_req_valid[2] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8", cl_rsp_valid, 3'b111);
        collect(2, 16'h3333, "R8");
        collect(1, 16'h2222, "R8");
        collect(0, 16'h4444, "R8");

        // Uncollected response on port 2
        issue(2, 1'b0, 16'h0005, '0);
        repeat (3) @(negedge clk);
        chk("R6", cl_rsp_valid[2], 1'b1);
        cl_req_valid[2] = 1'b1; cl_req_wr[2] = 1'b0; cl_req_addr[2] = 16'h0007;
        repeat (3) begin
            #9 chk("R6", cl_req_ready[2], 1'b0);
            @(negedge clk);
        end
        cl_req_wr[2] = 1'b1; cl_req_addr[2] = 16'h0009; cl_req_wdata[2] = 16'h5555;
        #9 chk("R6", cl_req_ready[2], 1'b1);
        @(negedge clk);
        cl_req_valid[2] = 1'b0;
        chk("R6", {last_wr, last_addr, last_wdata}, {1'b1, 16'h0009, 16'h5555});
        issue(0, 1'b0, 16'h0009, '0);
        collect(0, 16'h5555, "R7");
        chk("R9", cl_rsp_data[2], 16'h2222);
        collect(2, 16'h2222, "R9");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule